// File: doc/BRIEF.md
# DRAM Page-Mode Address Multiplexer

This block sits between a bus master and a DRAM array and turns a single request strobe with a byte address into a timed row and column sequence. It drives an active-low row strobe, an active-low column strobe and a DRAM address bus. A small control register sets four things: whether row and column are multiplexed onto the address pins, how far the row address is shifted down, whether fast page (burst) operation is used, and how long the column strobe stays high in each column cycle.

In fast page operation the block remembers the open row. A request whose upper address bits match that row skips the precharge and row phases and issues only a new column cycle. The same 2-bit field that picks the row shift also picks how many upper bits are compared, and this compare width applies whether or not multiplexing is on. A control register write, or a long idle spell, closes the open row so that the next access takes the full sequence.

Top module: `dram_pmux`

## Requirements
- R1: After reset the control register reads 0x0000. Writable fields are burst enable at bit 12, CAS duty at bit 11, multiplex enable at bit 10 and the shift code at bits 9:8. Bits 15:13 and 7:0 always read 0, so writing 0xFFFF reads back 0x1F00.
- R2: With multiplex enable at 0, the full request address is driven on `dram_addr` in both the row phase and the column phase.
- R3: With multiplex enable at 1, the row phase drives the address shifted right by 8, 9 or 10 bits for shift codes 00, 01 and 10, and the column phase drives the low 8, 9 or 10 address bits with all higher bits zero.
- R4: Shift code 11 behaves exactly like code 00, for both the row shift and the page compare width.
- R5: A full access holds `ras_n` high for PRE_CYC cycles (4), then drives `ras_n` low with the row address for RCD_CYC cycles (3), then runs one column cycle of TICKS cycles (20). `ack` is high in the last column cycle. This gives 27 cycles from the accepting edge to `ack`. `cas_n` is never low while `ras_n` is high.
- R6: With burst enable at 0, every access is a full access, and `ras_n` returns high once the access ends.
- R7: With burst enable at 1, a request whose address bits 27:S equal those of the open row (S = 8, 9 or 10 from the shift code, whether or not multiplexing is on) runs only a column cycle. This takes 20 cycles to `ack`, and `ras_n` stays low between accesses.
- R8: In each column cycle `cas_n` is low first and then high for the rest of the cycle. With CAS duty at 0 it is high for 10 of the 20 cycles; with CAS duty at 1 it is high for 7.
- R9: Any control register write closes the open row. `ras_n` goes high in the next cycle when idle, and the next access is a full access, even if the written value is unchanged.
- R10: If an open row sees IDLE_TO (32) consecutive idle cycles, it closes: `ras_n` goes high and the next access is a full access. A shorter idle spell keeps the row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| req | input | 1 | Access request, accepted when not busy |
| req_addr | input | 28 | Byte address of the access |
| busy | output | 1 | An access is in progress |
| ack | output | 1 | Last cycle of the access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | 28 | DRAM address, row or column |

## Verification
The hardest situation to create is a page hit whose outcome depends only on the compare width. That means two addresses that share bits 27:S for one shift code but not for another, under each code, including the reserved one and including multiplexing off. The table walk changes the configuration first, which forces a miss. It then issues an address inside the same row and one just past it, and it identifies a hit or a miss purely from the cycle count to `ack`. Directed tests then leave an open row idle for just under and well past the timeout, and rewrite an unchanged configuration, to show that the row closes only when it should.

// File: rtl/dram_pmux_pkg.sv
// Shared types and helpers for the DRAM page-mode address multiplexer.
// Assumes a 16-bit control register with fields at fixed bit positions.
package dram_pmux_pkg;

    localparam int CFG_W      = 16;
    localparam int BIT_BURST  = 12;
    localparam int BIT_DUTY   = 11;
    localparam int BIT_MUX    = 10;
    localparam int BIT_SH_LO  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_RAS,
        ST_COL
    } seq_state_e;

    typedef struct packed {
        logic       burst;
        logic       duty35;
        logic       mux;
        logic [1:0] shcode;
    } cfg_t;

    // Map the 2-bit shift code to a bit count; the reserved code acts as 00.
    function automatic logic [3:0] row_shift(input logic [1:0] code);
        case (code)
            2'b01:   row_shift = 4'd9;
            2'b10:   row_shift = 4'd10;
            default: row_shift = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/dram_pmux_cfg.sv
// Control register. Holds burst, duty, multiplex and shift fields.
// Assumes writes take effect on the next clock edge; unused bits read 0.
module dram_pmux_cfg
    import dram_pmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[15:13], wdata[7:0]};

    // Capture the writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.burst  <= wdata[BIT_BURST];
            cfg.duty35 <= wdata[BIT_DUTY];
            cfg.mux    <= wdata[BIT_MUX];
            cfg.shcode <= wdata[BIT_SH_LO+1:BIT_SH_LO];
        end
    end

    // Assemble the read view with zero reserved bits.
    always_comb begin
        rdata                         = '0;
        rdata[BIT_BURST]              = cfg.burst;
        rdata[BIT_DUTY]               = cfg.duty35;
        rdata[BIT_MUX]                = cfg.mux;
        rdata[BIT_SH_LO+1:BIT_SH_LO]  = cfg.shcode;
    end

endmodule

// File: rtl/dram_pmux_page.sv
// Open-row tracker. Stores the row of the last access, detects page hits
// over address bits AW-1:S, and closes the page on a register write or
// after IDLE_TO idle cycles. Assumes start and done come from the sequencer.
module dram_pmux_page
    import dram_pmux_pkg::*;
#(
    parameter int AW      = 28,
    parameter int IDLE_TO = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          burst,
    input  logic [3:0]    shift,
    input  logic [AW-1:0] addr,
    input  logic          start,
    input  logic          done,
    input  logic          idle,
    output logic          open_q,
    output logic          hit
);

    localparam int ITW = $clog2(IDLE_TO + 1);
    localparam logic [ITW-1:0] TO_LAST = ITW'(IDLE_TO - 1);

    logic [AW-1:0]  row_q;
    logic           dirty_q;
    logic [ITW-1:0] idle_cnt;
    logic [AW-1:0]  cmp_mask;
    logic           timeout;

    // Compare mask covering the row bits for the current shift code.
    always_comb begin
        cmp_mask = {AW{1'b1}} << shift;
        hit      = open_q && burst && !cfg_we && (((addr ^ row_q) & cmp_mask) == '0);
        timeout  = idle && open_q && (idle_cnt == TO_LAST);
    end

    // Remember the row of each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (start)
            row_q <= addr;
    end

    // Track register writes that land during an access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dirty_q <= 1'b0;
        else if (cfg_we)
            dirty_q <= 1'b1;
        else if (start)
            dirty_q <= 1'b0;
    end

    // Count idle cycles while a page is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !idle || !open_q)
            idle_cnt <= '0;
        else if (!timeout)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Open or close the page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (cfg_we || timeout)
            open_q <= 1'b0;
        else if (done)
            open_q <= burst && !dirty_q;
    end

endmodule

// File: rtl/dram_pmux_seq.sv
// Access sequencer. Runs precharge, row and column phases, drives the
// strobes and the multiplexed address. Assumes one tick per clock cycle
// and a request that is accepted only while idle.
module dram_pmux_seq
    import dram_pmux_pkg::*;
#(
    parameter int AW      = 28,
    parameter int TICKS   = 20,
    parameter int PRE_CYC = 4,
    parameter int RCD_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  cfg_t          cfg,
    input  logic          hit,
    input  logic          page_open,
    output logic          start,
    output logic          done,
    output logic          busy,
    output logic          ras_n,
    output logic          cas_n,
    output logic [AW-1:0] dram_addr
);

    localparam int HI50  = TICKS / 2;
    localparam int HI35  = (TICKS * 35) / 100;
    localparam int MAXA  = (TICKS > PRE_CYC) ? TICKS : PRE_CYC;
    localparam int MAXC  = (MAXA > RCD_CYC) ? MAXA : RCD_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] COL_LAST = CW'(TICKS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] RCD_LAST = CW'(RCD_CYC - 1);
    localparam logic [CW-1:0] LO50     = CW'(TICKS - HI50);
    localparam logic [CW-1:0] LO35     = CW'(TICKS - HI35);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] a_q;
    logic          mux_q;
    logic          duty_q;
    logic [3:0]    sh_q;
    logic [CW-1:0] lo_len;
    logic [AW-1:0] row_addr;
    logic [AW-1:0] col_addr;

    // Accept and finish strobes.
    always_comb begin
        start = req && (state_q == ST_IDLE);
        done  = (state_q == ST_COL) && (cnt_q == COL_LAST);
        busy  = (state_q != ST_IDLE);
    end

    // Snapshot address and settings at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            mux_q  <= 1'b0;
            duty_q <= 1'b0;
            sh_q   <= 4'd8;
        end else if (start) begin
            a_q    <= addr;
            mux_q  <= cfg.mux;
            duty_q <= cfg.duty35;
            sh_q   <= row_shift(cfg.shcode);
        end
    end

    // Phase state machine with a shared tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start)
                        state_q <= hit ? ST_COL : ST_PRE;
                end
                ST_PRE: begin
                    if (cnt_q == PRE_LAST) begin
                        state_q <= ST_RAS;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RAS: begin
                    if (cnt_q == RCD_LAST) begin
                        state_q <= ST_COL;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == COL_LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Row and column address forms.
    always_comb begin
        row_addr = mux_q ? (a_q >> sh_q) : a_q;
        col_addr = mux_q ? (a_q & ~({AW{1'b1}} << sh_q)) : a_q;
        lo_len   = duty_q ? LO35 : LO50;
    end

    // Strobe and address outputs per phase.
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        dram_addr = '0;
        case (state_q)
            ST_IDLE: ras_n = !page_open;
            ST_PRE:  dram_addr = row_addr;
            ST_RAS: begin
                ras_n     = 1'b0;
                dram_addr = row_addr;
            end
            default: begin
                ras_n     = 1'b0;
                cas_n     = !(cnt_q < lo_len);
                dram_addr = col_addr;
            end
        endcase
    end

endmodule

// File: rtl/dram_pmux.sv
// Top of the DRAM page-mode address multiplexer. Connects the control
// register, the open-row tracker and the access sequencer.
// Assumes a single master that waits for ack before the next request.
module dram_pmux
    import dram_pmux_pkg::*;
#(
    parameter int AW      = 28,
    parameter int TICKS   = 20,
    parameter int PRE_CYC = 4,
    parameter int RCD_CYC = 3,
    parameter int IDLE_TO = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          ack,
    output logic          ras_n,
    output logic          cas_n,
    output logic [AW-1:0] dram_addr
);

    cfg_t cfg;
    logic page_open;
    logic hit;
    logic start;
    logic done;

    dram_pmux_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    dram_pmux_page #(.AW(AW), .IDLE_TO(IDLE_TO)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (cfg_we),
        .burst  (cfg.burst),
        .shift  (row_shift(cfg.shcode)),
        .addr   (req_addr),
        .start  (start),
        .done   (done),
        .idle   (!busy),
        .open_q (page_open),
        .hit    (hit)
    );

    dram_pmux_seq #(.AW(AW), .TICKS(TICKS), .PRE_CYC(PRE_CYC), .RCD_CYC(RCD_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .addr      (req_addr),
        .cfg       (cfg),
        .hit       (hit),
        .page_open (page_open),
        .start     (start),
        .done      (done),
        .busy      (busy),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .dram_addr (dram_addr)
    );

    assign ack = done;

endmodule

// File: rtl/dram_pmux_chk.sv
// Protocol checker for the DRAM page-mode address multiplexer, bound to the top.
module dram_pmux_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic busy,
    input logic ack,
    input logic ras_n,
    input logic cas_n,
    input logic rd_burst
);

    p_cas_needs_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_row_before_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> cas_n);

    p_ack_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    p_nonburst_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rd_burst) |=> ras_n);

    p_write_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy) |=> ras_n);

endmodule

bind dram_pmux dram_pmux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .busy     (busy),
    .ack      (ack),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .rd_burst (cfg_rdata[12])
);

// File: tb/dram_pmux_bench.sv
module dram_pmux_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req = 1'b0;
    logic [27:0] req_addr = '0;
    logic        busy, ack, ras_n, cas_n;
    logic [27:0] dram_addr;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dram_pmux u_dram_pmux (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_addr(req_addr), .busy(busy),
        .ack(ack), .ras_n(ras_n), .cas_n(cas_n), .dram_addr(dram_addr)
    );

    // cfg(16) | addr(28) | expect hit(1)
    localparam int NV = 13;
    localparam logic [44:0] VEC [NV] = '{
        {16'h0000, 28'h0123456, 1'b0},
        {16'h0000, 28'h0123456, 1'b0},
        {16'h1400, 28'h0ABCD12, 1'b0},
        {16'h1400, 28'h0ABCDFF, 1'b1},
        {16'h1400, 28'h0ABCE00, 1'b0},
        {16'h1D01, 28'h0000300, 1'b0},
        {16'h1D01, 28'h00003FF, 1'b1},
        {16'h1202, 28'h1000000, 1'b0},
        {16'h1202, 28'h10003FF, 1'b1},
        {16'h1202, 28'h1000400, 1'b0},
        {16'h1703, 28'h0000155, 1'b0},
        {16'h1703, 28'h00001AA, 1'b1},
        {16'h1703, 28'h0000200, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [27:0] a, output int lat, output logic [27:0] row,
                          output logic [27:0] col, output int hi, output bit got_row);
        bit seen_col;
        @(negedge clk);
        req = 1'b1;
        req_addr = a;
        @(negedge clk);
        req = 1'b0;
        lat = 0; hi = 0; got_row = 0; seen_col = 0; row = '0; col = '0;
        for (int i = 0; i < 100; i++) begin
            lat++;
            if (!ras_n && cas_n && !seen_col && !got_row) begin
                row = dram_addr;
                got_row = 1;
            end
            if (!cas_n && !seen_col) begin
                col = dram_addr;
                seen_col = 1;
            end
            if (seen_col && cas_n) hi++;
            if (ack) break;
            @(negedge clk);
        end
    endtask

    // Expected row-phase address from R2, R3 and R4.
    function automatic logic [27:0] exp_row(input logic [15:0] c, input logic [27:0] a);
        int s;
        s = (c[9:8] == 2'b01) ? 9 : (c[9:8] == 2'b10) ? 10 : 8;
        exp_row = c[10] ? (a >> s) : a;
    endfunction

    function automatic logic [27:0] exp_col(input logic [15:0] c, input logic [27:0] a);
        int s;
        s = (c[9:8] == 2'b01) ? 9 : (c[9:8] == 2'b10) ? 10 : 8;
        exp_col = c[10] ? (a & ((28'h1 << s) - 28'h1)) : a;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, hi;
        logic [27:0] row, col;
        bit got_row;
        logic [15:0] prev;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset rdata", 32'(cfg_rdata), 32'h0);
        chk("R5 reset ras_n", 32'(ras_n), 32'h1);
        chk("R5 reset cas_n", 32'(cas_n), 32'h1);
        chk("R5 reset busy", 32'(busy), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle rdata", 32'(cfg_rdata), 32'h0);

        // Table walk
        prev = 16'hFFFF;
        for (int v = 0; v < NV; v++) begin
            logic [15:0] c;
            logic [27:0] a;
            logic        h;
            {c, a, h} = VEC[v];
            if (c != prev) begin
                wr_cfg(c);
                @(negedge clk);
                prev = c;
            end
            access(a, lat, row, col, hi, got_row);
            chk(c[12] ? "R7 latency" : "R6 latency", 32'(lat), h ? 32'd20 : 32'd27);
            if (!h) chk(c[10] ? "R3 row addr" : "R2 row addr", 32'(row), 32'(exp_row(c, a)));
            if (c[9:8] == 2'b11 && !h) chk("R4 row addr code 11", 32'(row), 32'(exp_row(c, a)));
            chk(c[10] ? "R3 col addr" : "R2 col addr", 32'(col), 32'(exp_col(c, a)));
            chk("R8 cas high ticks", 32'(hi), c[11] ? 32'd7 : 32'd10);
            @(negedge clk);
            chk(c[12] ? "R7 ras held low" : "R6 ras released", 32'(ras_n), c[12] ? 32'h0 : 32'h1);
        end

        // R1 reserved bits
        wr_cfg(16'hFFFF);
        chk("R1 reserved read zero", 32'(cfg_rdata), 32'h1F00);

        // R9 rewrite of the same value closes the row
        wr_cfg(16'h1400);
        access(28'h0000100, lat, row, col, hi, got_row);
        chk("R9 first miss", 32'(lat), 32'd27);
        access(28'h0000100, lat, row, col, hi, got_row);
        chk("R9 then hit", 32'(lat), 32'd20);
        wr_cfg(16'h1400);
        chk("R9 ras_n after write", 32'(ras_n), 32'h1);
        access(28'h0000100, lat, row, col, hi, got_row);
        chk("R9 miss after write", 32'(lat), 32'd27);

        // R10 idle timeout
        repeat (5) @(negedge clk);
        access(28'h0000100, lat, row, col, hi, got_row);
        chk("R10 short idle keeps row", 32'(lat), 32'd20);
        repeat (60) @(negedge clk);
        chk("R10 ras_n after timeout", 32'(ras_n), 32'h1);
        access(28'h0000100, lat, row, col, hi, got_row);
        chk("R10 miss after timeout", 32'(lat), 32'd27);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule